// File: doc/BRIEF.md
# Program-Flow Execution Unit

This unit carries out the control-transfer part of a 16-bit accumulator machine. Each cycle in which `issue` is high, it decodes the presented instruction word and works out the next instruction pointer. It uses the status flags, the resolved source operand and the current pointer. It covers relative and absolute jumps, conditional jumps, and decrement-and-branch on one of two loop counters. It also covers calls, conditional returns, interrupt returns, and explicit push and pop through a private 16-entry return stack.

Bit 15 of the word picks the source kind: 0 means the low byte is an 8-bit signed immediate, and 1 means a register supplies `src_val`. Bits 11:8 pick the group: `1100` is the jump/return group and `1101` is the stack and loop group. Bits 14:12 hold a condition code shared by jumps and returns. The top of the stack is always visible on `tos`, so a pop consumer can take the value in the same cycle. The unit keeps an in-service flag. Interrupt entry sets it from outside, and a taken interrupt return clears it.

Top module: `flow_ctl`

## Requirements
- R1: Condition codes in bits 14:12 are evaluated as follows: 000 always, 010 C, 110 not C, 001 Z, 101 not Z, 011 E, 111 not E, 100 S. A jump (bits 11:8 = 1100, not a return form) that is taken loads the target. An untaken jump sets the pointer to IP+1.
- R2: With bit 15 = 0, the target is IP plus the sign-extended low byte. With bit 15 = 1, the target is `src_val` taken as an absolute address.
- R3: A jump or return whose bits 14:13 together with bit 12 give condition 011 or 111, with bit 15 = 1, is invalid. It raises `bad_op`, advances the pointer to IP+1 and leaves the stack unchanged.
- R4: Decrement-and-branch (bits 14:13 = 10, bits 11:8 = 1101) decrements loop counter 0 or 1, as selected by bit 12, and writes the result back. It branches only when the new value is nonzero; otherwise the pointer goes to IP+1. The other counter is not touched.
- R5: A call (bits 14:12 = 011, bits 11:8 = 1101) increments SP, stores IP+1 at the new SP and loads the target.
- R6: A return (bit 15 = 1, bits 11:8 = 1100, low byte 0x0D) that is taken loads IP from the entry at SP and then decrements SP. An untaken return changes neither SP nor the flag state, and the pointer goes to IP+1.
- R7: An interrupt return (low byte 0x8D) behaves as a return and, when taken, also clears `ins`. `ins_set` raises `ins` and takes priority.
- R8: Push (bits 14:12 = 000, bits 11:8 = 1101) stores `src_val` at the pre-incremented SP. Pop (bit 15 = 1, low byte 0x0D or 0x8D, any group other than 1100 and 1101) presents the value at SP on `tos` and then decrements SP. Both advance the pointer to IP+1.
- R9: An instruction that pops its source (bit 15 = 1, low byte 0x0D or 0x8D) while it is also a push, call or decrement-and-branch is invalid. It raises `bad_op`, leaves SP and the stack unchanged, and advances the pointer to IP+1.
- R10: A push or call made while 16 entries are live sets the sticky `ovf_err`. A pop or taken return made with no live entry sets the sticky `unf_err`. SP wraps modulo 16 in both cases.
- R11: Reset clears IP, SP, `ins`, both loop counters and both error flags.
- R12: While `issue` is low, IP, SP and the loop counters hold their values. The exception is `lc_load`, which writes `src_val` into the counter selected by `lc_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Execute `instr` this cycle |
| instr | input | 16 | Instruction word |
| src_val | input | 16 | Resolved source operand |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_e | input | 1 | Equal flag |
| ins_set | input | 1 | Interrupt entry, sets the in-service flag |
| lc_load | input | 1 | Load a loop counter from `src_val` |
| lc_sel | input | 1 | Loop counter selected by `lc_load` |
| ip | output | 16 | Instruction pointer |
| sp | output | 4 | Stack pointer |
| tos | output | 16 | Stack entry at SP |
| loop0 | output | 16 | Loop counter 0 |
| loop1 | output | 16 | Loop counter 1 |
| ins | output | 1 | In-service flag |
| bad_op | output | 1 | Current instruction is invalid |
| ovf_err | output | 1 | Sticky stack overflow |
| unf_err | output | 1 | Sticky stack underflow |

## Verification
A wrong stack pointer or a corrupted entry shows on `tos` in the cycle right after the faulty push or pop. The wrong value then reaches `ip` one cycle after the next return. Errors in the live-entry count stay hidden until the stack is filled or drained, so the stress sequence walks the count across both the empty and the full limit. A bad loop counter shows on `loop0`/`loop1` at once, and reaches `ip` one cycle after the next decrement-and-branch.

// File: rtl/flow_ctl.sv
module flow_ctl #(
  parameter int W   = 16,
  parameter int SPW = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue,
  input  logic [15:0]  instr,
  input  logic [W-1:0] src_val,
  input  logic         flag_c,
  input  logic         flag_z,
  input  logic         flag_s,
  input  logic         flag_e,
  input  logic         ins_set,
  input  logic         lc_load,
  input  logic         lc_sel,
  output logic [W-1:0] ip,
  output logic [SPW-1:0] sp,
  output logic [W-1:0] tos,
  output logic [W-1:0] loop0,
  output logic [W-1:0] loop1,
  output logic         ins,
  output logic         bad_op,
  output logic         ovf_err,
  output logic         unf_err
);
  localparam int DEPTH = 1 << SPW;

  logic [W-1:0] stk [DEPTH];
  logic [SPW:0] live;
  logic         cond_ok;
  logic [W-1:0] ip_nx;

  wire       src_reg = instr[15];
  wire [2:0] cc      = instr[14:12];
  wire [3:0] grp     = instr[11:8];
  wire [7:0] lo      = instr[7:0];

  wire pop_src  = src_reg && lo[6:0] == 7'h0D;
  wire is_jfam  = grp == 4'hC;
  wire is_ret   = is_jfam && pop_src;
  wire is_jump  = is_jfam && !pop_src;
  wire is_push  = grp == 4'hD && cc == 3'b000;
  wire is_call  = grp == 4'hD && cc == 3'b011;
  wire is_djnz  = grp == 4'hD && cc[2:1] == 2'b10;
  wire is_pop   = pop_src && !is_jfam && grp != 4'hD;
  wire en_reg   = is_jfam && src_reg && cc[1:0] == 2'b11;

  assign bad_op = en_reg || (pop_src && (is_push || is_call || is_djnz));

  wire ok       = issue && !bad_op;
  wire do_push  = ok && (is_push || is_call);
  wire do_pop   = ok && (is_pop || (is_ret && cond_ok));

  wire [W-1:0]   ip_inc = ip + 1'b1;
  wire [W-1:0]   target = src_reg ? src_val : ip + {{(W-8){lo[7]}}, lo};
  wire [W-1:0]   lc_dec = (cc[0] ? loop1 : loop0) - 1'b1;
  wire [SPW-1:0] sp_up  = sp + 1'b1;
  wire [SPW-1:0] sp_dn  = sp - 1'b1;

  assign tos = stk[sp];

  always_comb begin
    case (cc)
      3'b000:  cond_ok = 1'b1;
      3'b010:  cond_ok = flag_c;
      3'b110:  cond_ok = !flag_c;
      3'b001:  cond_ok = flag_z;
      3'b101:  cond_ok = !flag_z;
      3'b011:  cond_ok = flag_e;
      3'b111:  cond_ok = !flag_e;
      default: cond_ok = flag_s;
    endcase
  end

  always_comb begin
    ip_nx = ip_inc;
    if (ok) begin
      if (is_ret && cond_ok)       ip_nx = stk[sp];
      else if (is_jump && cond_ok) ip_nx = target;
      else if (is_call)            ip_nx = target;
      else if (is_djnz && lc_dec != '0) ip_nx = target;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) stk[sp_up] <= is_call ? ip_inc : src_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ip      <= '0;
      sp      <= '0;
      live    <= '0;
      loop0   <= '0;
      loop1   <= '0;
      ins     <= 1'b0;
      ovf_err <= 1'b0;
      unf_err <= 1'b0;
    end else begin
      if (issue) ip <= ip_nx;
      if (do_push) begin
        sp <= sp_up;
        if (live == DEPTH[SPW:0]) ovf_err <= 1'b1;
        else live <= live + 1'b1;
      end
      if (do_pop) begin
        sp <= sp_dn;
        if (live == '0) unf_err <= 1'b1;
        else live <= live - 1'b1;
      end
      if (ok && is_djnz) begin
        if (cc[0]) loop1 <= lc_dec;
        else       loop0 <= lc_dec;
      end
      if (lc_load) begin
        if (lc_sel) loop1 <= src_val;
        else        loop0 <= src_val;
      end
      if (ins_set) ins <= 1'b1;
      else if (do_pop && is_ret && lo[7]) ins <= 1'b0;
    end
  end
endmodule

module flow_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        issue,
  input logic [15:0] instr,
  input logic        ins_set,
  input logic [15:0] ip,
  input logic [3:0]  sp,
  input logic        ins,
  input logic        bad_op,
  input logic        ovf_err,
  input logic        unf_err
);
  assert_idle_ip_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> ip == $past(ip));
  assert_bad_keeps_sp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    issue && bad_op |=> sp == $past(sp));
  assert_reg_enjump_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue && instr[15] && instr[11:8] == 4'hC && instr[13:12] == 2'b11 |-> bad_op);
  assert_push_sp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !bad_op && instr[14:8] == 7'h0D |=> sp == $past(sp) + 4'd1);
  assert_call_sp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !bad_op && instr[14:8] == 7'h3D |=> sp == $past(sp) + 4'd1);
  assert_reti_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue && instr == 16'h8C8D && !ins_set |=> !ins);
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
  assert_unf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    unf_err |=> unf_err);
endmodule

bind flow_ctl flow_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .ins_set(ins_set),
  .ip(ip), .sp(sp), .ins(ins), .bad_op(bad_op), .ovf_err(ovf_err), .unf_err(unf_err)
);

// File: tb/test_flow_ctl.sv
module test_flow_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] src_val = '0;
  logic        flag_c = 1'b0, flag_z = 1'b0, flag_s = 1'b0, flag_e = 1'b0;
  logic        ins_set = 1'b0, lc_load = 1'b0, lc_sel = 1'b0;
  logic [15:0] ip, tos, loop0, loop1;
  logic [3:0]  sp;
  logic        ins, bad_op, ovf_err, unf_err;
  logic        bad_seen;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  flow_ctl i_flow_ctl (
    .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .src_val(src_val),
    .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_e(flag_e),
    .ins_set(ins_set), .lc_load(lc_load), .lc_sel(lc_sel),
    .ip(ip), .sp(sp), .tos(tos), .loop0(loop0), .loop1(loop1), .ins(ins),
    .bad_op(bad_op), .ovf_err(ovf_err), .unf_err(unf_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic exec(input logic [15:0] w, input logic [15:0] s);
    @(negedge clk);
    instr = w; src_val = s; issue = 1'b1;
    #1 bad_seen = bad_op;
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic load_lc(input logic sel, input logic [15:0] v);
    @(negedge clk);
    lc_sel = sel; src_val = v; lc_load = 1'b1;
    @(negedge clk);
    lc_load = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 ip", ip, 0); chk("R11 sp", sp, 0); chk("R11 ins", ins, 0);
    chk("R11 loop0", loop0, 0); chk("R11 loop1", loop1, 0);
    chk("R11 errs", {ovf_err, unf_err}, 0);
  endtask

  task automatic t_jumps;
    exec(16'h0C05, 0);                chk("R1 R2 always rel", ip, 16'h0005);
    flag_c = 0; exec(16'h2C03, 0);    chk("R1 C untaken", ip, 16'h0006);
    flag_c = 1; exec(16'h2C03, 0);    chk("R1 C taken", ip, 16'h0009);
    exec(16'h6C10, 0);                chk("R1 NC untaken", ip, 16'h000A);
    flag_z = 1; exec(16'h1CFE, 0);    chk("R2 Z neg offset", ip, 16'h0008);
    exec(16'h5C01, 0);                chk("R1 NZ untaken", ip, 16'h0009);
    flag_s = 1; exec(16'h4C02, 0);    chk("R1 S taken", ip, 16'h000B);
    flag_e = 1; exec(16'h3C01, 0);    chk("R1 E taken", ip, 16'h000C);
    exec(16'h7C01, 0);                chk("R1 NE untaken", ip, 16'h000D);
    exec(16'h8C20, 16'h1234);         chk("R2 absolute", ip, 16'h1234);
    exec(16'hBC20, 16'h5000);         chk("R3 reg E bad", bad_seen, 1);
    chk("R3 ip", ip, 16'h1235);       chk("R3 sp", sp, 0);
    flag_c = 0; flag_z = 0; flag_s = 0; flag_e = 0;
  endtask

  task automatic t_djnz;
    load_lc(0, 16'd2);
    exec(16'h4D03, 0);   chk("R4 taken ip", ip, 16'h1238); chk("R4 lc0", loop0, 1);
    exec(16'h4D03, 0);   chk("R4 zero ip", ip, 16'h1239);  chk("R4 lc0 zero", loop0, 0);
    load_lc(1, 16'd5);
    exec(16'hDD22, 16'h0100); chk("R4 lc1 ip", ip, 16'h0100); chk("R4 lc1", loop1, 4);
    chk("R4 lc0 kept", loop0, 0);
  endtask

  task automatic t_call_ret;
    exec(16'h3D10, 0);   chk("R5 ip", ip, 16'h0110); chk("R5 sp", sp, 1); chk("R5 tos", tos, 16'h0101);
    flag_z = 1; exec(16'hDC0D, 0); chk("R6 untaken ip", ip, 16'h0111); chk("R6 untaken sp", sp, 1);
    flag_z = 0; exec(16'h8C0D, 0); chk("R6 ret ip", ip, 16'h0101); chk("R6 ret sp", sp, 0);
  endtask

  task automatic t_reti;
    @(negedge clk); ins_set = 1; @(negedge clk); ins_set = 0;
    chk("R7 set", ins, 1);
    exec(16'hBD30, 16'h0400); chk("R5 reg call", ip, 16'h0400);
    flag_c = 0; exec(16'hAC8D, 0); chk("R7 untaken ins", ins, 1); chk("R7 untaken ip", ip, 16'h0401);
    flag_c = 1; exec(16'hAC8D, 0); chk("R7 ins cleared", ins, 0); chk("R7 ip", ip, 16'h0102);
    chk("R7 sp", sp, 0); flag_c = 0;
  endtask

  task automatic t_pushpop;
    exec(16'h0D77, 16'hABCD); chk("R8 push imm", tos, 16'hABCD); chk("R8 sp1", sp, 1);
    exec(16'h8D22, 16'h1111); chk("R8 push reg", tos, 16'h1111); chk("R8 sp2", sp, 2);
    exec(16'h8E0D, 0);        chk("R8 pop sp", sp, 1); chk("R8 pop tos", tos, 16'hABCD);
    chk("R8 ip", ip, 16'h0105);
  endtask

  task automatic t_conflict;
    exec(16'h8D0D, 16'h7777); chk("R9 push-pop bad", bad_seen, 1);
    chk("R9 sp", sp, 1); chk("R9 tos", tos, 16'hABCD); chk("R9 ip", ip, 16'h0106);
    exec(16'hBD0D, 16'h0900); chk("R9 call-pop bad", bad_seen, 1);
    chk("R9 call sp", sp, 1); chk("R9 call ip", ip, 16'h0107);
  endtask

  task automatic t_limits;
    exec(16'h8E0D, 0); chk("R10 no unf", unf_err, 0); chk("R10 sp0", sp, 0);
    exec(16'h8E0D, 0); chk("R10 unf", unf_err, 1); chk("R10 wrap", sp, 15);
    for (int k = 0; k < 16; k++) exec(16'h0D01, 16'(k));
    chk("R10 full no ovf", ovf_err, 0); chk("R10 sp full", sp, 15);
    exec(16'h0D01, 16'hEEEE); chk("R10 ovf", ovf_err, 1); chk("R10 unf sticky", unf_err, 1);
  endtask

  task automatic t_idle;
    logic [15:0] ip0;
    logic [3:0]  sp0;
    ip0 = ip; sp0 = sp;
    @(negedge clk); instr = 16'h0C40; issue = 0; @(negedge clk);
    chk("R12 ip hold", ip, ip0); chk("R12 sp hold", sp, sp0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_jumps;
    t_djnz;
    t_call_ret;
    t_reti;
    t_pushpop;
    t_conflict;
    t_limits;
    t_idle;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule